// File: doc/BRIEF.md
# Periodic Timer Comparator Channel

This block is a memory-mapped timer with a 64-bit free-running main counter and one comparator channel. The channel raises an interrupt when the counter reaches the comparator value. In periodic mode the comparator then advances by a hidden period value, which sets up the next match. In one-shot mode the comparator is left as it is. Software reaches the block through a word-addressed register port that has a one-cycle write strobe and a one-cycle read strobe.

A period can be programmed while the counter is away from zero. Software arms a self-clearing set-value control in the channel configuration. The next comparator write then places the first match, and the write after it changes only the hidden period. The channel can also run in a narrow 32-bit mode, where it compares against the low counter half and its sums wrap. A legacy-routing flag in the global configuration appears on an output pin for the interrupt fabric around the block.

Top module: `ptimer_top`

## Requirements
- R1: While the run bit (global config, address 0, bit 0) is set, the counter (address 1) rises by exactly one on each clock. While the run bit is clear, it holds its value.
- R2: A counter write is accepted only while the run bit is clear. A counter write made while the run bit is set is ignored.
- R3: With set-value not armed, a comparator write (address 3) loads the written value into both the comparator and the hidden period.
- R4: The set-value bit (channel config, address 2, bit 2) always reads as 0. Writing it as 1 arms a two-write sequence. The first comparator write after arming updates both registers. The second updates only the period and leaves the comparator unchanged. Later writes behave as in R3.
- R5: When the channel is enabled (config bit 0) and periodic (config bit 1), and the running counter equals the comparator, status is set and the comparator advances by the period at the next edge.
- R6: With config bit 1 clear (one-shot), a match sets status and leaves the comparator unchanged.
- R7: With config bit 3 set (32-bit mode), written comparator and period values are cut to 32 bits and the upper halves read as zero. A match compares only the counter's low 32 bits, and the reload sum wraps modulo 2^32.
- R8: Status (address 4, bit 0) is set by a match and cleared by writing 1 to bit 0. When both happen in the same cycle, the set wins.
- R9: `irq` is high exactly when status is set and the channel is enabled. A disabled channel never sets status.
- R10: `legacy_route` follows global config bit 1.
- R11: A comparator write in the same cycle as a periodic match takes priority over the reload.
- R12: Every register resets to zero. `rdata` presents the addressed register one cycle after `rd_en`, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 3 | Word address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, registered |
| irq | output | 1 | Channel interrupt |
| legacy_route | output | 1 | Legacy routing flag |

## Verification
The assertions assume the register port carries at most one access per cycle, so a configuration write and a comparator write never arrive together. They also assume that `wdata` is held stable while `wr_en` is high. The bench drives each access for exactly one clock, on the falling edge, and leaves the strobes low between operations. The assertions also assume the narrow width is below the counter width, which holds for the defaults the bench uses. Timing-sensitive runs start from a stopped counter with known values, so the stimulus places each match on an exact cycle.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_GCFG = 3'd0,
    REG_CNT  = 3'd1,
    REG_CCFG = 3'd2,
    REG_CMP  = 3'd3,
    REG_STS  = 3'd4
  } reg_addr_e;

  // global config bit positions
  localparam int G_RUN    = 0;
  localparam int G_LEGACY = 1;

  // channel config bit positions
  localparam int C_EN     = 0;
  localparam int C_PER    = 1;
  localparam int C_SETVAL = 2;
  localparam int C_NARROW = 3;

  typedef enum logic [1:0] {
    SV_IDLE   = 2'd0,
    SV_FIRST  = 2'd1,
    SV_SECOND = 2'd2
  } setval_e;
endpackage

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else if (ld)  cnt <= ld_val;
  end
endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wdata_lo,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [3:0]        ccfg_rd,
  input  logic [CNT_W-1:0]  cmp,
  input  logic              sts,
  output logic              run,
  output logic              legacy,
  output logic              wr_cnt,
  output logic              wr_ccfg,
  output logic              wr_cmp,
  output logic              wr_sts,
  output logic [CNT_W-1:0]  rdata
);
  logic             wr_gcfg;
  logic [CNT_W-1:0] rd_mux;

  assign wr_gcfg = wr_en && (addr == REG_GCFG);
  assign wr_cnt  = wr_en && (addr == REG_CNT);
  assign wr_ccfg = wr_en && (addr == REG_CCFG);
  assign wr_cmp  = wr_en && (addr == REG_CMP);
  assign wr_sts  = wr_en && (addr == REG_STS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      legacy <= 1'b0;
    end else if (wr_gcfg) begin
      run    <= wdata_lo[G_RUN];
      legacy <= wdata_lo[G_LEGACY];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      REG_GCFG: rd_mux[1:0] = {legacy, run};
      REG_CNT:  rd_mux      = cnt;
      REG_CCFG: rd_mux[3:0] = ccfg_rd;
      REG_CMP:  rd_mux      = cmp;
      REG_STS:  rd_mux[0]   = sts;
      default:  rd_mux      = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/ptimer_channel.sv
module ptimer_channel
  import ptimer_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_ccfg,
  input  logic             wr_cmp,
  input  logic             wr_sts,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cmp_q,
  output logic [3:0]       ccfg_rd,
  output logic             sts_q,
  output logic             irq,
  output logic             hit,
  output logic             en_q,
  output logic             narrow_q,
  output logic             setval_second
);
  localparam int HI_W = CNT_W - NARROW_W;

  logic             per_q;
  logic [CNT_W-1:0] period_q;
  setval_e          sv_q;
  logic             eq;
  logic [CNT_W-1:0] cmp_d, period_d;
  logic             narrow_d;

  function automatic logic [CNT_W-1:0] fit(input logic [CNT_W-1:0] v, input logic nar);
    fit = nar ? {{HI_W{1'b0}}, v[NARROW_W-1:0]} : v;
  endfunction

  generate
    if (HI_W > 0) begin : g_split_cmp
      assign eq = narrow_q ? (cnt[NARROW_W-1:0] == cmp_q[NARROW_W-1:0])
                           : (cnt == cmp_q);
    end else begin : g_full_cmp
      assign eq = (cnt == cmp_q);
    end
  endgenerate

  assign hit           = run && en_q && eq;
  assign setval_second = (sv_q == SV_SECOND);
  assign ccfg_rd       = {narrow_q, 1'b0, per_q, en_q};
  assign irq           = sts_q && en_q;
  assign narrow_d      = wr_ccfg ? wdata[C_NARROW] : narrow_q;

  always_comb begin
    cmp_d    = cmp_q;
    period_d = period_q;
    if (wr_cmp) begin
      period_d = fit(wdata, narrow_q);
      if (sv_q != SV_SECOND) cmp_d = fit(wdata, narrow_q);
    end else if (hit && per_q) begin
      cmp_d = cmp_q + period_q;
    end
    cmp_d    = fit(cmp_d, narrow_d);
    period_d = fit(period_d, narrow_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      narrow_q <= 1'b0;
      sv_q     <= SV_IDLE;
      cmp_q    <= '0;
      period_q <= '0;
      sts_q    <= 1'b0;
    end else begin
      cmp_q    <= cmp_d;
      period_q <= period_d;
      narrow_q <= narrow_d;
      if (wr_ccfg) begin
        en_q  <= wdata[C_EN];
        per_q <= wdata[C_PER];
        if (wdata[C_SETVAL]) sv_q <= SV_FIRST;
      end else if (wr_cmp) begin
        case (sv_q)
          SV_FIRST:  sv_q <= SV_SECOND;
          SV_SECOND: sv_q <= SV_IDLE;
          default:   sv_q <= SV_IDLE;
        endcase
      end
      if (hit)                    sts_q <= 1'b1;
      else if (wr_sts && wdata[0]) sts_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic              legacy_route
);
  logic             run, wr_cnt, wr_ccfg, wr_cmp, wr_sts;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic [3:0]       ccfg_rd;
  logic             sts_q, hit, en_q, narrow_q, setval_second;

  ptimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata_lo(wdata[1:0]), .cnt(cnt_q), .ccfg_rd(ccfg_rd), .cmp(cmp_q),
    .sts(sts_q), .run(run), .legacy(legacy_route), .wr_cnt(wr_cnt),
    .wr_ccfg(wr_ccfg), .wr_cmp(wr_cmp), .wr_sts(wr_sts), .rdata(rdata)
  );

  ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .ld(wr_cnt), .ld_val(wdata),
    .cnt(cnt_q)
  );

  ptimer_channel #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt_q), .wr_ccfg(wr_ccfg),
    .wr_cmp(wr_cmp), .wr_sts(wr_sts), .wdata(wdata), .cmp_q(cmp_q),
    .ccfg_rd(ccfg_rd), .sts_q(sts_q), .irq(irq), .hit(hit), .en_q(en_q),
    .narrow_q(narrow_q), .setval_second(setval_second)
  );
endmodule

// File: rtl/ptimer_top_chk.sv
module ptimer_top_chk #(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             wr_cnt,
  input logic             wr_cmp,
  input logic             wr_ccfg,
  input logic             setval_second,
  input logic             narrow,
  input logic             en,
  input logic             irq,
  input logic             sts,
  input logic             hit,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic [CNT_W-1:0] wdata
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + 1'b1);

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt));

  // R4
  setval_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmp && setval_second) |=> $stable(cmp));

  // R11
  cmp_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmp && !setval_second && !narrow && !wr_ccfg) |=> cmp == $past(wdata));

  // R7
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> cmp[CNT_W-1:NARROW_W] == '0);

  // R8
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> sts);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);
endmodule

bind ptimer_top ptimer_top_chk #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .wr_cnt(wr_cnt), .wr_cmp(wr_cmp),
  .wr_ccfg(wr_ccfg), .setval_second(setval_second), .narrow(narrow_q),
  .en(en_q), .irq(irq), .sts(sts_q), .hit(hit), .cnt(cnt_q), .cmp(cmp_q),
  .wdata(wdata)
);

// File: tb/ptimer_top_tb.sv
module ptimer_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 44;

  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_WT = 2'd2} op_e;
  typedef struct packed {
    op_e         op;
    logic [2:0]  a;
    logic [63:0] d;
    logic [63:0] e;
  } vec_t;

  localparam vec_t VEC [N_VEC] = '{
    '{OP_RD, 3'd0, 64'd0, 64'd0},            // R12 reset
    '{OP_RD, 3'd2, 64'd0, 64'd0},            // R12
    '{OP_RD, 3'd3, 64'd0, 64'd0},            // R12
    '{OP_WR, 3'd1, 64'd100, 64'd0},          // R2 load stopped
    '{OP_RD, 3'd1, 64'd0, 64'd100},          // R2
    '{OP_WR, 3'd2, 64'd7, 64'd0},            // R4 arm
    '{OP_RD, 3'd2, 64'd0, 64'd3},            // R4 reads 0
    '{OP_WR, 3'd3, 64'd110, 64'd0},          // R4 first
    '{OP_WR, 3'd3, 64'd5, 64'd0},            // R4 second
    '{OP_RD, 3'd3, 64'd0, 64'd110},          // R4
    '{OP_WR, 3'd0, 64'd3, 64'd0},            // run
    '{OP_WT, 3'd0, 64'd13, 64'd0},
    '{OP_WR, 3'd0, 64'd2, 64'd0},            // stop
    '{OP_RD, 3'd3, 64'd0, 64'd115},          // R5 reload
    '{OP_RD, 3'd1, 64'd0, 64'd114},          // R1
    '{OP_RD, 3'd4, 64'd0, 64'd1},            // R5 status
    '{OP_WR, 3'd4, 64'd1, 64'd0},            // R8 clear
    '{OP_RD, 3'd4, 64'd0, 64'd0},            // R8
    '{OP_WR, 3'd3, 64'd500, 64'd0},          // R3
    '{OP_WR, 3'd0, 64'd3, 64'd0},
    '{OP_WR, 3'd1, 64'd0, 64'd0},            // R2 ignored
    '{OP_WR, 3'd0, 64'd0, 64'd0},
    '{OP_RD, 3'd1, 64'd0, 64'd116},          // R2
    '{OP_WR, 3'd1, 64'h1_FFFF_FFF0, 64'd0},
    '{OP_WR, 3'd2, 64'd15, 64'd0},           // R7 narrow + arm
    '{OP_WR, 3'd3, 64'hAB_FFFF_FFF8, 64'd0},
    '{OP_WR, 3'd3, 64'h10, 64'd0},
    '{OP_RD, 3'd3, 64'd0, 64'hFFFF_FFF8},    // R7 truncated
    '{OP_WR, 3'd0, 64'd1, 64'd0},
    '{OP_WT, 3'd0, 64'd9, 64'd0},
    '{OP_WR, 3'd0, 64'd0, 64'd0},
    '{OP_RD, 3'd3, 64'd0, 64'h8},            // R7 wrap
    '{OP_RD, 3'd4, 64'd0, 64'd1},            // R7 low-half match
    '{OP_RD, 3'd1, 64'd0, 64'h1_FFFF_FFFA},  // R1
    '{OP_WR, 3'd4, 64'd1, 64'd0},
    '{OP_WR, 3'd2, 64'd1, 64'd0},            // R6 one-shot
    '{OP_WR, 3'd1, 64'h20, 64'd0},
    '{OP_WR, 3'd3, 64'h24, 64'd0},
    '{OP_WR, 3'd0, 64'd1, 64'd0},
    '{OP_WT, 3'd0, 64'd5, 64'd0},
    '{OP_WR, 3'd0, 64'd0, 64'd0},
    '{OP_RD, 3'd3, 64'd0, 64'h24},           // R6 unchanged
    '{OP_RD, 3'd4, 64'd0, 64'd1},            // R6 status
    '{OP_RD, 3'd1, 64'd0, 64'h26}            // R1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq, legacy_route;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  ptimer_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .legacy_route(legacy_route)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [63:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [63:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    // R12 reset outputs
    chk("R12 rdata at reset", rdata, 64'd0);
    chk("R9 irq at reset", {63'd0, irq}, 64'd0);
    chk("R10 legacy at reset", {63'd0, legacy_route}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < N_VEC; k++) begin
      case (VEC[k].op)
        OP_WR: bus_wr(VEC[k].a, VEC[k].d);
        OP_WT: idle(int'(VEC[k].d));
        default: begin
          bus_rd(VEC[k].a, r);
          chk($sformatf("vector %0d (R1..R8 table)", k), r, VEC[k].e);
        end
      endcase
    end

    // R9 interrupt gated by channel enable (status is set here)
    chk("R9 irq enabled", {63'd0, irq}, 64'd1);
    bus_wr(3'd2, 64'd0);
    chk("R9 irq disabled", {63'd0, irq}, 64'd0);
    bus_wr(3'd2, 64'd1);
    chk("R9 irq re-enabled", {63'd0, irq}, 64'd1);

    // R10 legacy routing pin
    bus_wr(3'd0, 64'd2);
    chk("R10 legacy set", {63'd0, legacy_route}, 64'd1);
    bus_wr(3'd0, 64'd0);
    chk("R10 legacy clear", {63'd0, legacy_route}, 64'd0);

    // R12 unmapped address reads zero
    bus_rd(3'd6, r);
    chk("R12 unmapped read", r, 64'd0);

    // R11 comparator write on the match cycle wins over reload
    bus_wr(3'd4, 64'd1);
    bus_wr(3'd2, 64'd3);
    bus_wr(3'd1, 64'h40);
    bus_wr(3'd3, 64'h42);
    bus_wr(3'd0, 64'd1);
    idle(2);
    bus_wr(3'd3, 64'h80);
    bus_wr(3'd0, 64'd0);
    bus_rd(3'd3, r);
    chk("R11 write beats reload", r, 64'h80);
    bus_rd(3'd4, r);
    chk("R8 status set by match", r, 64'd1);

    // R4 third write after arming acts normally
    bus_wr(3'd2, 64'd7);
    bus_wr(3'd3, 64'h200);
    bus_wr(3'd3, 64'h300);
    bus_rd(3'd3, r);
    chk("R4 second write keeps comparator", r, 64'h200);
    bus_wr(3'd3, 64'h400);
    bus_rd(3'd3, r);
    chk("R4 third write updates comparator", r, 64'h400);

    finish_run();
  end
endmodule